// File: doc/BRIEF.md
# Load Buffer with Common-Data-Bus Wakeup

This block holds renamed load instructions for an out-of-order core until they can be sent to data memory. When the dispatch stage offers a load, the load goes into a free slot. The slot stores a producer tag, a base value and an immediate offset. A tag of zero means the base value is already valid. A nonzero tag names the instruction that will produce the base value.

Each waiting slot watches the result bus. When the bus carries the slot's tag, the slot takes the broadcast data as its base value and clears its tag. Ready slots ask an external arbiter for a result-bus slot. They ask at the moment the load issues, because the bus will be used a fixed memory latency later. The cycle after a grant, the buffer drives a one-cycle memory read at base plus offset.

A one-hot shift register in the slot counts the memory latency. The slot is released on the clock edge after the read completes. Slots are numbered from 1, and the slot number offered to the next load is visible on a port, so that the rename stage can use it as the load's own tag.

Top module: `load_buffer`

## Requirements
- R1: After reset, `can_accept` is 1, `next_slot` is 1, `arb_req` is 0, `rd_en` is 0 and `rd_complete` is 0.
- R2: Slots are numbered 1 to N_ENTRY. A load offered with `ld_valid` goes into the lowest-numbered free slot. `next_slot` always shows that slot number while any slot is free.
- R3: A slot allocated with a nonzero tag does not make `arb_req` rise. A broadcast whose tag differs from the slot's tag does not wake it.
- R4: A broadcast whose `bus_tag` equals a waiting slot's tag is captured on that clock edge. `bus_data` becomes the slot's base value, and `arb_req` is high in the following cycle.
- R5: A slot allocated with tag 0 is ready at once. `arb_req` is high in the cycle right after the allocating edge.
- R6: When `arb_req` and `arb_grant` are both high at a clock edge, `rd_en` is high for the next cycle. In that cycle `rd_addr` equals (base + offset) modulo 2^ADDR_W.
- R7: Among ready slots, only the lowest-numbered one is issued on a grant. Without a grant, a ready slot keeps `arb_req` high.
- R8: If `rd_en` is high after edge k, `rd_complete` is high after edge k+MEM_LAT. The slot is free after edge k+MEM_LAT+1, and `next_slot` and `can_accept` show this.
- R9: When every slot is busy, `can_accept` is 0, `next_slot` holds its last value, and `ld_valid` is ignored.
- R10: If a nonzero `ld_tag` equals `bus_tag` in the allocating cycle, the slot captures `bus_data` as its base value and is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Dispatch offers a load this cycle |
| ld_tag | input | TAG_W | Producer tag of the base operand; 0 means the base value is valid |
| ld_base | input | DATA_W | Base value, used when the tag is 0 |
| ld_imm | input | OFF_W | Immediate offset |
| bus_tag | input | TAG_W | Tag broadcast on the result bus; 0 means no broadcast |
| bus_data | input | DATA_W | Data broadcast on the result bus |
| arb_grant | input | 1 | The arbiter grants the current request |
| can_accept | output | 1 | At least one slot is free |
| next_slot | output | IDX_W | Number of the slot the next load will occupy |
| arb_req | output | 1 | Some slot is ready and requests a bus slot |
| rd_en | output | 1 | Memory read strobe, one cycle per issued load |
| rd_addr | output | ADDR_W | Memory read address |
| rd_complete | output | 1 | A memory read finishes this cycle |

## Verification
The bench builds the buffer with three slots, 8-bit data, offset and address, and a memory latency of 3. With three slots, the full condition is reached after a few loads, so the ignored-offer and held-slot-number behaviour can be tested. The narrow address makes base plus offset wrap (200 + 100 gives 44). The latency of 3 separates the read strobe, the completion pulse and the release edge into distinct cycles. With several ready slots waiting at once, the scoreboard checks the order of read addresses, and this confirms the lowest-slot-first priority.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    LB_FREE  = 2'd0,
    LB_WAIT  = 2'd1,
    LB_READY = 2'd2,
    LB_MEM   = 2'd3
  } lb_state_e;
endpackage

// File: rtl/lb_entry.sv
module lb_entry
  import lb_pkg::*;
#(
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16,
  parameter int OFF_W   = 16,
  parameter int MEM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  input  logic              issue_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] val_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              done_o
);
  localparam int SH_W = MEM_LAT + 1;

  lb_state_e         state_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;
  logic [OFF_W-1:0]  off_q;
  logic [SH_W-1:0]   shift_q;

  // named events for the checks
  logic snoop_hit;
  logic alloc_bypass;
  logic alloc_ready;

  assign snoop_hit    = (state_q == LB_WAIT) && (tag_q == cdb_tag_i);
  assign alloc_bypass = (tag_i != '0) && (tag_i == cdb_tag_i);
  assign alloc_ready  = (tag_i == '0) || alloc_bypass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LB_FREE;
      tag_q   <= '0;
      val_q   <= '0;
      off_q   <= '0;
      shift_q <= '0;
    end else begin
      unique case (state_q)
        LB_FREE: begin
          if (alloc_i) begin
            tag_q   <= alloc_bypass ? '0 : tag_i;
            val_q   <= alloc_bypass ? cdb_data_i : val_i;
            off_q   <= off_i;
            state_q <= alloc_ready ? LB_READY : LB_WAIT;
          end
        end
        LB_WAIT: begin
          if (snoop_hit) begin
            tag_q   <= '0;
            val_q   <= cdb_data_i;
            state_q <= LB_READY;
          end
        end
        LB_READY: begin
          if (issue_i) begin
            shift_q <= SH_W'(1);
            state_q <= LB_MEM;
          end
        end
        LB_MEM: begin
          if (shift_q[MEM_LAT]) begin
            shift_q <= '0;
            state_q <= LB_FREE;
          end else begin
            shift_q <= shift_q << 1;
          end
        end
        default: state_q <= LB_FREE;
      endcase
    end
  end

  assign busy_o  = (state_q != LB_FREE);
  assign ready_o = (state_q == LB_READY);
  assign val_o   = val_q;
  assign off_o   = off_q;
  assign done_o  = (state_q == LB_MEM) && shift_q[MEM_LAT];

  // R4
  wake_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_hit |=> (ready_o && val_o == $past(cdb_data_i)));

  // R7
  issue_only_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> ready_o);

  // R8
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R3
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LB_WAIT && !snoop_hit) |=> !ready_o);
endmodule

// File: rtl/lb_alloc.sv
module lb_alloc #(
  parameter int N_ENTRY = 4,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic [N_ENTRY-1:0] busy_i,
  output logic               ok_o,
  output logic [IDX_W-1:0]   slot_o,
  output logic [N_ENTRY-1:0] alloc_oh_o
);
  logic [N_ENTRY-1:0] free_oh;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   hold_q;

  function automatic logic [N_ENTRY-1:0] lowest_clear(input logic [N_ENTRY-1:0] v);
    logic [N_ENTRY-1:0] r;
    r = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (!v[i]) r = N_ENTRY'(1) << i;
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input logic [N_ENTRY-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_ENTRY; i++) begin
      if (oh[i]) r = IDX_W'(i + 1);
    end
    return r;
  endfunction

  assign free_oh  = lowest_clear(busy_i);
  assign free_idx = slot_of(free_oh);
  assign ok_o     = ~&busy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= IDX_W'(1);
    else if (ok_o) hold_q <= free_idx;
  end

  assign slot_o = ok_o ? free_idx : hold_q;

  genvar g;
  generate
    for (g = 0; g < N_ENTRY; g++) begin : g_dec
      assign alloc_oh_o[g] = sel_i && ok_o && free_oh[g];
    end
  endgenerate

  // R2
  alloc_into_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_oh_o != '0) |=> ((busy_i & $past(alloc_oh_o)) == $past(alloc_oh_o)));

  // R9
  hold_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_o |=> (ok_o || $stable(slot_o)));
endmodule

// File: rtl/lb_issue.sv
module lb_issue #(
  parameter int N_ENTRY = 4,
  parameter int DATA_W  = 16,
  parameter int OFF_W   = 16,
  parameter int ADDR_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_ENTRY-1:0]             ready_i,
  input  logic [N_ENTRY-1:0][DATA_W-1:0] val_i,
  input  logic [N_ENTRY-1:0][OFF_W-1:0]  off_i,
  input  logic                           grant_i,
  output logic                           req_o,
  output logic [N_ENTRY-1:0]             issue_oh_o,
  output logic                           mem_read_o,
  output logic [ADDR_W-1:0]              mem_raddr_o
);
  logic [N_ENTRY-1:0] win_oh;
  logic [DATA_W-1:0]  win_val;
  logic [OFF_W-1:0]   win_off;
  logic               fire;
  logic               rd_q;
  logic [ADDR_W-1:0]  addr_q;

  function automatic logic [ADDR_W-1:0] eff_addr(input logic [DATA_W-1:0] base,
                                                  input logic [OFF_W-1:0]  off);
    return ADDR_W'(base) + ADDR_W'(off);
  endfunction

  always_comb begin
    logic found;
    found  = 1'b0;
    win_oh = '0;
    for (int i = 0; i < N_ENTRY; i++) begin
      if (ready_i[i] && !found) begin
        win_oh[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    win_val = '0;
    win_off = '0;
    for (int i = 0; i < N_ENTRY; i++) begin
      win_val = win_val | (win_oh[i] ? val_i[i] : '0);
      win_off = win_off | (win_oh[i] ? off_i[i] : '0);
    end
  end

  assign req_o      = |ready_i;
  assign fire       = req_o && grant_i;
  assign issue_oh_o = fire ? win_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q <= fire;
      if (fire) addr_q <= eff_addr(win_val, win_off);
    end
  end

  assign mem_read_o  = rd_q;
  assign mem_raddr_o = addr_q;

  // R7
  single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_oh_o));

  // R6
  read_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && grant_i) |=> mem_read_o);

  // R6
  no_read_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_o && grant_i) |=> !mem_read_o);
endmodule

// File: rtl/load_buffer.sv
module load_buffer #(
  parameter int N_ENTRY = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16,
  parameter int OFF_W   = 16,
  parameter int ADDR_W  = 16,
  parameter int MEM_LAT = 2,
  parameter int IDX_W   = $clog2(N_ENTRY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [DATA_W-1:0] ld_base,
  input  logic [OFF_W-1:0]  ld_imm,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              arb_grant,
  output logic              can_accept,
  output logic [IDX_W-1:0]  next_slot,
  output logic              arb_req,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_complete
);
  logic [N_ENTRY-1:0]             alloc_oh;
  logic [N_ENTRY-1:0]             issue_oh;
  logic [N_ENTRY-1:0]             busy_vec;
  logic [N_ENTRY-1:0]             ready_vec;
  logic [N_ENTRY-1:0]             done_vec;
  logic [N_ENTRY-1:0][DATA_W-1:0] val_vec;
  logic [N_ENTRY-1:0][OFF_W-1:0]  off_vec;

  lb_alloc #(.N_ENTRY(N_ENTRY), .IDX_W(IDX_W)) u_alloc (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (ld_valid),
    .busy_i     (busy_vec),
    .ok_o       (can_accept),
    .slot_o     (next_slot),
    .alloc_oh_o (alloc_oh)
  );

  genvar g;
  generate
    for (g = 0; g < N_ENTRY; g++) begin : g_slot
      lb_entry #(
        .TAG_W(TAG_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .MEM_LAT(MEM_LAT)
      ) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_i    (alloc_oh[g]),
        .tag_i      (ld_tag),
        .val_i      (ld_base),
        .off_i      (ld_imm),
        .cdb_tag_i  (bus_tag),
        .cdb_data_i (bus_data),
        .issue_i    (issue_oh[g]),
        .busy_o     (busy_vec[g]),
        .ready_o    (ready_vec[g]),
        .val_o      (val_vec[g]),
        .off_o      (off_vec[g]),
        .done_o     (done_vec[g])
      );
    end
  endgenerate

  lb_issue #(
    .N_ENTRY(N_ENTRY), .DATA_W(DATA_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_i     (ready_vec),
    .val_i       (val_vec),
    .off_i       (off_vec),
    .grant_i     (arb_grant),
    .req_o       (arb_req),
    .issue_oh_o  (issue_oh),
    .mem_read_o  (rd_en),
    .mem_raddr_o (rd_addr)
  );

  assign rd_complete = |done_vec;

  // R9
  full_ignores_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!can_accept && ld_valid && done_vec == '0) |=> (busy_vec == $past(busy_vec)));

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (next_slot >= IDX_W'(1)) && (next_slot <= IDX_W'(N_ENTRY)));

  // R3
  req_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_req |-> (ready_vec != '0));

  // R8
  complete_one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec));
endmodule

// File: tb/test_load_buffer.sv
module test_load_buffer;
  localparam int N   = 3;
  localparam int TW  = 4;
  localparam int DW  = 8;
  localparam int OW  = 8;
  localparam int AW  = 8;
  localparam int LAT = 3;
  localparam int IW  = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic [TW-1:0] ld_tag = '0;
  logic [DW-1:0] ld_base = '0;
  logic [OW-1:0] ld_imm = '0;
  logic [TW-1:0] bus_tag = '0;
  logic [DW-1:0] bus_data = '0;
  logic          arb_grant = 1'b0;
  logic          can_accept;
  logic [IW-1:0] next_slot;
  logic          arb_req;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          rd_complete;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [AW-1:0] exp_addr[$];
  int done_at[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  load_buffer #(
    .N_ENTRY(N), .TAG_W(TW), .DATA_W(DW), .OFF_W(OW), .ADDR_W(AW), .MEM_LAT(LAT)
  ) i_load_buffer (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_tag(ld_tag),
    .ld_base(ld_base), .ld_imm(ld_imm), .bus_tag(bus_tag), .bus_data(bus_data),
    .arb_grant(arb_grant), .can_accept(can_accept), .next_slot(next_slot),
    .arb_req(arb_req), .rd_en(rd_en), .rd_addr(rd_addr), .rd_complete(rd_complete)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic nb();
    @(negedge clk);
  endtask

  // driver side: expected address from the requirement, base + offset wrapped
  task automatic expect_read(input int base, input int off);
    exp_addr.push_back(AW'(base + off));
  endtask

  // monitor: reads and completions
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (rd_en) begin
        if (exp_addr.size() == 0) begin
          check("R6 unexpected read", 1, 0);
        end else begin
          check("R6 read address", int'(rd_addr), int'(exp_addr.pop_front()));
        end
        done_at.push_back(cyc + LAT);
      end
      begin
        bit want;
        want = (done_at.size() > 0) && (done_at[0] == cyc);
        if (want || rd_complete) check("R8 completion pulse", int'(rd_complete), int'(want));
        if (want) void'(done_at.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) nb();
    rst_n = 1'b1;
    nb();
    // R1 reset state
    check("R1 can_accept", int'(can_accept), 1);
    check("R1 next_slot", int'(next_slot), 1);
    check("R1 arb_req", int'(arb_req), 0);
    check("R1 rd_en", int'(rd_en), 0);
    check("R1 rd_complete", int'(rd_complete), 0);

    // waiting load, woken by matching broadcast
    ld_valid = 1; ld_tag = 10; ld_base = 10; ld_imm = 20;
    expect_read(30, 20);
    nb();
    ld_valid = 0; ld_tag = 0;
    check("R2 next_slot after first", int'(next_slot), 2);
    check("R3 pending tag no req", int'(arb_req), 0);
    bus_tag = 9; bus_data = 99;
    nb();
    bus_tag = 0;
    check("R3 non-matching tag no wake", int'(arb_req), 0);
    bus_tag = 10; bus_data = 30;
    nb();
    bus_tag = 0;
    check("R4 req after wakeup", int'(arb_req), 1);
    arb_grant = 1;
    nb();
    arb_grant = 0;
    check("R6 rd_en after grant", int'(rd_en), 1);
    check("R6 no req after issue", int'(arb_req), 0);
    repeat (3) nb();
    check("R8 complete seen", int'(rd_complete), 1);
    check("R8 slot still busy", int'(next_slot), 2);
    nb();
    check("R8 slot freed", int'(next_slot), 1);

    // zero tag, address wrap, request persists
    ld_valid = 1; ld_tag = 0; ld_base = 200; ld_imm = 100;
    expect_read(200, 100);
    nb();
    ld_valid = 0;
    check("R5 ready at once", int'(arb_req), 1);
    nb();
    check("R7 req persists without grant", int'(arb_req), 1);
    arb_grant = 1;
    nb();
    arb_grant = 0;
    check("R6 wrapped read", int'(rd_addr), 44);
    repeat (5) nb();

    // fill, priority, ignored offer
    ld_valid = 1; ld_tag = 3; ld_base = 1; ld_imm = 1;
    nb();
    ld_tag = 0; ld_base = 2; ld_imm = 2;
    nb();
    ld_tag = 0; ld_base = 3; ld_imm = 3;
    nb();
    check("R9 full can_accept", int'(can_accept), 0);
    check("R9 held slot", int'(next_slot), 3);
    ld_tag = 0; ld_base = 50; ld_imm = 50;
    nb();
    ld_valid = 0;
    check("R9 still full", int'(can_accept), 0);
    check("R9 slot held", int'(next_slot), 3);
    check("R7 req with ready slots", int'(arb_req), 1);
    expect_read(2, 2);
    expect_read(3, 3);
    arb_grant = 1;
    nb();
    nb();
    arb_grant = 0;
    check("R3 waiting slot no req", int'(arb_req), 0);
    bus_tag = 3; bus_data = 9;
    expect_read(9, 1);
    nb();
    bus_tag = 0;
    check("R4 late wakeup req", int'(arb_req), 1);
    arb_grant = 1;
    nb();
    arb_grant = 0;
    repeat (8) nb();
    check("R8 all free", int'(can_accept), 1);
    check("R2 lowest slot again", int'(next_slot), 1);

    // bypass at allocation
    ld_valid = 1; ld_tag = 5; ld_base = 0; ld_imm = 1;
    bus_tag = 5; bus_data = 7;
    expect_read(7, 1);
    nb();
    ld_valid = 0; ld_tag = 0; bus_tag = 0;
    check("R10 bypass ready", int'(arb_req), 1);
    arb_grant = 1;
    nb();
    arb_grant = 0;
    repeat (6) nb();

    check("R6 all reads seen", exp_addr.size(), 0);
    check("R8 all completions seen", done_at.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule